// File: doc/BRIEF.md
# Byte-Granular Register Pair Shifter

This block moves whole bytes within an accumulator (A) and its extension register (X). Each register has five bytes and a separate sign bit. A sign bit of 1 means minus. There are six shift operations:
- move A left or right on its own;
- move A and X left or right as one ten-byte value;
- rotate A and X as one ten-byte value, left or right.

In the ten-byte modes A supplies the five high bytes and X the five low bytes. The sign bits are never changed.

A caller presents the operands, the operation and an unsigned byte count, then pulses `start`. Two clock cycles later the block raises `done` for one cycle. At that point the new A and X are on the outputs, and they stay there until the next result. Decoding and writing the result back into a register file are left to the caller.

Top module: `regpair_shifter`

## Requirements
- R1: The output sign bits `a_sign_o` and `x_sign_o` always equal the input sign bits captured with the accepted `start`, for every operation code.
- R2: Operation codes 0 (A left) and 1 (A right) return X unchanged. Only A's five bytes move, with zero bytes filling in. Byte 1 is the most significant byte, in bits [29:24] of a magnitude.
- R3: Codes 2 (pair left) and 3 (pair right) shift the 60-bit value {A,X} by count bytes. Zero bytes fill in and bytes shifted out are lost.
- R4: For codes 0 and 1, a count of 5 or more gives A = 0.
- R5: For codes 2 and 3, a count of 10 or more gives A = 0 and X = 0.
- R6: Codes 4 (rotate left) and 5 (rotate right) rotate {A,X} by (count mod 10) bytes. Bytes leaving one end enter at the other.
- R7: `done` is high exactly in the second cycle after the cycle in which `start` was accepted, and for one cycle only. `busy` is high in both cycles after acceptance and low otherwise.
- R8: A `start` while `busy` is high is ignored. Neither the result nor the timing of the operation in progress changes.
- R9: Codes 6 and 7 return A and X unchanged.
- R10: After reset, `busy` and `done` are low and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; sampled when idle |
| op_i | input | 3 | Operation code (see R2 to R9) |
| cnt_i | input | 12 | Unsigned byte count |
| a_sign_i | input | 1 | Sign of A, 1 = minus |
| a_mag_i | input | 30 | Five bytes of A |
| x_sign_i | input | 1 | Sign of X, 1 = minus |
| x_mag_i | input | 30 | Five bytes of X |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| a_sign_o | output | 1 | Result sign of A |
| a_mag_o | output | 30 | Result bytes of A |
| x_sign_o | output | 1 | Result sign of X |
| x_mag_o | output | 30 | Result bytes of X |

## Verification
The assertions compare the outputs with port values seen two edges earlier. This holds only if the operands and the operation code are sampled on the same edge as the accepted `start`, which the block guarantees by capturing them there. The bench holds the inputs steady around that edge. It also drives a second `start` with different data while the block is busy, to show that the block does not latch that data. The counts used cover every value from 0 to 12, plus large values (501, 1000, 4095), so the clear and wrap boundaries are exercised on both sides.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [2:0] {
    SH_LA = 3'd0,
    SH_RA = 3'd1,
    SH_LP = 3'd2,
    SH_RP = 3'd3,
    SH_LC = 3'd4,
    SH_RC = 3'd5,
    SH_N6 = 3'd6,
    SH_N7 = 3'd7
  } shop_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CALC = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/shift_seq.sv
module shift_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic load_res,
  output logic busy,
  output logic done
);
  import shifter_pkg::*;

  phase_e ph_q;

  assign accept   = start && (ph_q == PH_IDLE);
  assign load_res = (ph_q == PH_CALC);
  assign busy     = (ph_q != PH_IDLE);
  assign done     = (ph_q == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) ph_q <= PH_CALC;
        PH_CALC: ph_q <= PH_DONE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !done)); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> done); // R8
endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int NB = 5,
  parameter int BW = 6,
  parameter int CW = 12
) (
  input  logic [2:0]       op,
  input  logic [CW-1:0]    cnt,
  input  logic [NB*BW-1:0] a_in,
  input  logic [NB*BW-1:0] x_in,
  output logic [NB*BW-1:0] a_out,
  output logic [NB*BW-1:0] x_out
);
  import shifter_pkg::*;

  localparam int RW = NB * BW;
  localparam int PW = 2 * RW;
  localparam int NP = 2 * NB;

  function automatic logic [RW-1:0] reg_shift(logic [RW-1:0] v, int k, logic left);
    if (k >= NB) return '0;
    return left ? (v << (k * BW)) : (v >> (k * BW));
  endfunction

  function automatic logic [PW-1:0] pair_shift(logic [PW-1:0] v, int k, logic left);
    if (k >= NP) return '0;
    return left ? (v << (k * BW)) : (v >> (k * BW));
  endfunction

  function automatic logic [PW-1:0] pair_rotl(logic [PW-1:0] v, int r);
    if (r == 0) return v;
    return (v << (r * BW)) | (v >> ((NP - r) * BW));
  endfunction

  int            cnt_int;
  int            rot_left_amt;
  int            rot_right_amt;
  logic          cnt_clears_reg;
  logic          cnt_clears_pair;
  logic [PW-1:0] pair_in;
  logic [PW-1:0] pair_res;

  assign cnt_int         = int'(cnt);
  assign rot_left_amt    = int'(cnt % CW'(NP));
  assign rot_right_amt   = (rot_left_amt == 0) ? 0 : (NP - rot_left_amt);
  assign cnt_clears_reg  = (cnt_int >= NB);
  assign cnt_clears_pair = (cnt_int >= NP);
  assign pair_in         = {a_in, x_in};

  always_comb begin
    pair_res = pair_in;
    unique case (shop_e'(op))
      SH_LA:   pair_res = {reg_shift(a_in, cnt_int, 1'b1), x_in};
      SH_RA:   pair_res = {reg_shift(a_in, cnt_int, 1'b0), x_in};
      SH_LP:   pair_res = pair_shift(pair_in, cnt_int, 1'b1);
      SH_RP:   pair_res = pair_shift(pair_in, cnt_int, 1'b0);
      SH_LC:   pair_res = pair_rotl(pair_in, rot_left_amt);
      SH_RC:   pair_res = pair_rotl(pair_in, rot_right_amt);
      default: pair_res = pair_in;
    endcase
  end

  assign a_out = pair_res[PW-1:RW];
  assign x_out = pair_res[RW-1:0];

  always_comb begin
    AST_ROT_RANGE: assert (rot_left_amt >= 0 && rot_left_amt < NP); // R6
    if (cnt_clears_reg && (op == SH_LA || op == SH_RA))
      AST_REG_CLEAR: assert (a_out == '0); // R4
    if (cnt_clears_pair && (op == SH_LP || op == SH_RP))
      AST_PAIR_CLEAR: assert (pair_res == '0); // R5
  end
endmodule

// File: rtl/regpair_shifter.sv
module regpair_shifter #(
  parameter int NB = 5,
  parameter int BW = 6,
  parameter int CW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             a_sign_i,
  input  logic [NB*BW-1:0] a_mag_i,
  input  logic             x_sign_i,
  input  logic [NB*BW-1:0] x_mag_i,
  output logic             busy,
  output logic             done,
  output logic             a_sign_o,
  output logic [NB*BW-1:0] a_mag_o,
  output logic             x_sign_o,
  output logic [NB*BW-1:0] x_mag_o
);
  localparam int RW = NB * BW;

  logic          accept;
  logic          load_res;
  logic [2:0]    cap_op;
  logic [CW-1:0] cap_cnt;
  logic          cap_as;
  logic          cap_xs;
  logic [RW-1:0] cap_a;
  logic [RW-1:0] cap_x;
  logic [RW-1:0] new_a;
  logic [RW-1:0] new_x;

  shift_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept   (accept),
    .load_res (load_res),
    .busy     (busy),
    .done     (done)
  );

  shift_core #(.NB(NB), .BW(BW), .CW(CW)) u_core (
    .op    (cap_op),
    .cnt   (cap_cnt),
    .a_in  (cap_a),
    .x_in  (cap_x),
    .a_out (new_a),
    .x_out (new_x)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op  <= '0;
      cap_cnt <= '0;
      cap_as  <= 1'b0;
      cap_xs  <= 1'b0;
      cap_a   <= '0;
      cap_x   <= '0;
    end else if (accept) begin
      cap_op  <= op_i;
      cap_cnt <= cnt_i;
      cap_as  <= a_sign_i;
      cap_xs  <= x_sign_i;
      cap_a   <= a_mag_i;
      cap_x   <= x_mag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sign_o <= 1'b0;
      x_sign_o <= 1'b0;
      a_mag_o  <= '0;
      x_mag_o  <= '0;
    end else if (load_res) begin
      a_sign_o <= cap_as;
      x_sign_o <= cap_xs;
      a_mag_o  <= new_a;
      x_mag_o  <= new_x;
    end
  end

  AST_DONE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept, 2)); // R7
  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (a_sign_o == $past(a_sign_i, 2) && x_sign_o == $past(x_sign_i, 2))); // R1
  AST_X_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op_i, 2) <= 3'd1) |-> (x_mag_o == $past(x_mag_i, 2))); // R2
  AST_ROT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(op_i, 2) == 3'd4 || $past(op_i, 2) == 3'd5)) |->
      ($countones({a_mag_o, x_mag_o}) == $countones($past({a_mag_i, x_mag_i}, 2)))); // R6
  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op_i, 2) >= 3'd6) |->
      ({a_mag_o, x_mag_o} == $past({a_mag_i, x_mag_i}, 2))); // R9
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_res && !done) |=> $stable({a_sign_o, a_mag_o, x_sign_o, x_mag_o})); // R8
endmodule

// File: tb/sim_regpair_shifter.sv
module sim_regpair_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_i = '0;
  logic [11:0] cnt_i = '0;
  logic        a_sign_i = 1'b0;
  logic [29:0] a_mag_i = '0;
  logic        x_sign_i = 1'b0;
  logic [29:0] x_mag_i = '0;
  logic        busy, done, a_sign_o, x_sign_o;
  logic [29:0] a_mag_o, x_mag_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  regpair_shifter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .cnt_i(cnt_i),
    .a_sign_i(a_sign_i), .a_mag_i(a_mag_i), .x_sign_i(x_sign_i), .x_mag_i(x_mag_i),
    .busy(busy), .done(done), .a_sign_o(a_sign_o), .a_mag_o(a_mag_o),
    .x_sign_o(x_sign_o), .x_mag_o(x_mag_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] pk(int b1, int b2, int b3, int b4, int b5);
    return {6'(b1), 6'(b2), 6'(b3), 6'(b4), 6'(b5)};
  endfunction

  // byte-index model: index 0 = most significant byte of A, 9 = least of X
  function automatic logic [59:0] model(int op, int c, logic [29:0] a, logic [29:0] x);
    int b[10];
    int n[10];
    logic [59:0] r;
    for (int i = 0; i < 5; i++) begin
      b[i]     = int'(a[(4-i)*6 +: 6]);
      b[i + 5] = int'(x[(4-i)*6 +: 6]);
    end
    for (int i = 0; i < 10; i++) begin
      n[i] = b[i];
      case (op)
        0: if (i < 5) n[i] = (i + c < 5) ? b[i + c] : 0;
        1: if (i < 5) n[i] = (i >= c) ? b[i - c] : 0;
        2: n[i] = (i + c < 10) ? b[i + c] : 0;
        3: n[i] = (i >= c) ? b[i - c] : 0;
        4: n[i] = b[(i + (c % 10)) % 10];
        5: n[i] = b[(i + 10 - (c % 10)) % 10];
        default: n[i] = b[i];
      endcase
    end
    for (int i = 0; i < 10; i++) r[(9-i)*6 +: 6] = 6'(n[i]);
    return r;
  endfunction

  string tag_of[8] = '{"R2 R4", "R2 R4", "R3 R5", "R3 R5", "R6", "R6", "R9", "R9"};

  task automatic run(int op, int c, logic as, logic [29:0] a, logic xs, logic [29:0] x,
                     logic intrude);
    logic [59:0] e;
    e = model(op, c, a, x);
    @(negedge clk);
    chk("R7 idle before start", {62'd0, busy, done}, 64'd0);
    op_i = 3'(op); cnt_i = 12'(c); a_sign_i = as; a_mag_i = a; x_sign_i = xs; x_mag_i = x;
    start = 1'b1;
    @(negedge clk);
    chk("R7 first cycle", {62'd0, busy, done}, 64'd2);
    if (intrude) begin
      op_i = 3'd6; a_mag_i = ~a; x_mag_i = ~x; a_sign_i = ~as; x_sign_i = ~xs;
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done cycle", {62'd0, busy, done}, 64'd3);
    chk({tag_of[op], " bytes"}, {4'd0, a_mag_o, x_mag_o}, {4'd0, e});
    chk("R1 signs", {62'd0, a_sign_o, x_sign_o}, {62'd0, as, xs});
    @(negedge clk);
    chk("R7 single pulse", {62'd0, busy, done}, 64'd0);
    if (intrude) chk("R8 result kept", {4'd0, a_mag_o, x_mag_o}, {4'd0, e});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [29:0] pa, px;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {busy, done, a_sign_o, x_sign_o, a_mag_o, x_mag_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {62'd0, busy, done}, 64'd0);

    // worked sequence
    run(3, 1, 1'b0, pk(1,2,3,4,5), 1'b1, pk(6,7,8,9,10), 1'b0);
    chk("R3 seq a", {34'd0, a_mag_o}, {34'd0, pk(0,1,2,3,4)});
    chk("R3 seq x", {34'd0, x_mag_o}, {34'd0, pk(5,6,7,8,9)});
    run(0, 2, 1'b0, a_mag_o, 1'b1, x_mag_o, 1'b0);
    chk("R2 seq a", {34'd0, a_mag_o}, {34'd0, pk(2,3,4,0,0)});
    run(5, 4, 1'b0, a_mag_o, 1'b1, x_mag_o, 1'b0);
    chk("R6 seq a", {34'd0, a_mag_o}, {34'd0, pk(6,7,8,9,2)});
    chk("R6 seq x", {34'd0, x_mag_o}, {34'd0, pk(3,4,0,0,5)});
    run(1, 2, 1'b0, a_mag_o, 1'b1, x_mag_o, 1'b0);
    chk("R2 seq a2", {34'd0, a_mag_o}, {34'd0, pk(0,0,6,7,8)});
    run(4, 501, 1'b0, a_mag_o, 1'b1, x_mag_o, 1'b0);
    chk("R6 seq a 501", {34'd0, a_mag_o}, {34'd0, pk(0,6,7,8,3)});
    chk("R6 seq x 501", {34'd0, x_mag_o}, {34'd0, pk(4,0,0,5,0)});

    // sweep: every op, counts 0..12 and large values, two patterns
    for (int p = 0; p < 2; p++) begin
      pa = (p == 0) ? pk(1,2,3,4,5) : pk(63,0,42,21,7);
      px = (p == 0) ? pk(6,7,8,9,10) : pk(33,62,1,18,55);
      for (int op = 0; op < 8; op++) begin
        for (int c = 0; c < 16; c++) begin
          int cv;
          cv = (c < 13) ? c : ((c == 13) ? 501 : ((c == 14) ? 1000 : 4095));
          run(op, cv, 1'(p), pa, 1'(op & 1), px, 1'b0);
        end
      end
    end

    // start while busy is ignored
    run(2, 3, 1'b1, pk(9,8,7,6,5), 1'b0, pk(4,3,2,1,11), 1'b1);
    run(5, 7, 1'b0, pk(12,13,14,15,16), 1'b1, pk(17,18,19,20,21), 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule